// File: doc/BRIEF.md
# Seconds Countdown Alarm with Wake

The block is a relative alarm that counts seconds. Software writes an interval, in whole seconds, into a load register. Writing this register also copies the value into a remaining-count register. While the run bit is set, every one-cycle pulse on the seconds tick input takes one off the remaining count. When the count moves from one to zero, the block latches a pending flag. The count then rests at zero until software loads it again.

The pending flag can reach the system through two outputs:
- an interrupt line, gated by an interrupt-enable bit;
- a wake line, gated by a separate wake-enable bit.

Software clears the flag by writing a one to bit 0 of the status register.

A typical reprogramming sequence runs in this order:
1. Stop the countdown.
2. Clear the pending flag.
3. Load zero.
4. Load the new interval.
5. Restart the countdown.

Register access uses a single-cycle write port and a combinational read port. Register addresses:

| Address | Register |
|---|---|
| 0 | interval |
| 1 | remaining, read only |
| 2 | run enable |
| 3 | interrupt enable |
| 4 | pending status |
| 5 | wake enable |

The single-bit registers use bit 0. All other addresses read as zero.

Top module: `sec_countdown_alarm`

## Requirements
- R1: After reset every register reads zero, and `irq` and `wake` are low.
- R2: A write to address 0 stores the interval, which reads back at address 0. The same write sets the remaining count at address 1 to the written value on the next cycle.
- R3: On a cycle with `sec_tick` high, run enable (address 2, bit 0) set and a nonzero count, the remaining count drops by exactly one. The count is unchanged without a tick or with run enable clear.
- R4: The tick that takes an enabled count from 1 to 0 sets pending (address 4, bit 0). Further ticks leave the count at zero.
- R5: Loading an interval of 0 while run enable is set never raises pending.
- R6: Writing a value with bit 0 set to address 4 clears pending. A write with bit 0 clear leaves pending unchanged.
- R7: `irq` equals pending AND interrupt enable (address 3, bit 0).
- R8: `wake` equals pending AND wake enable (address 5, bit 0).
- R9: When a clear of pending and an expiry fall in the same cycle, pending stays set.
- R10: When an interval load and a tick fall in the same cycle, the remaining count takes the loaded value with no decrement.
- R11: Writes to address 1 are ignored, and the remaining count is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | CNT_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | CNT_W | Combinational read data |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | Wake request |

## Verification
The bench drives the same inputs into a behavioural model and compares `irq`, `wake` and the addressed read value on every cycle. Directed sequences then go after the collisions:
- **Clear and expiry in the same cycle.** A design that let the clear win would drop an alarm.
- **Load and tick in the same cycle.** A design that decremented the fresh value would fire one second early.
- **Zero interval loaded while running.** A design that treated zero as expiry would raise a spurious interrupt.
- **Ticks after expiry.** A design that let the count wrap below zero would fire again about 136 years later, or at once on a narrow counter.

A random phase follows. It mixes ticks with writes to every address, including the read-only one.

// File: rtl/sec_countdown_alarm.sv
module sec_countdown_alarm #(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  output logic              irq,
  output logic              wake
);

  localparam logic [ADDR_W-1:0] A_IVL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_REM = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_RUN = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_IEN = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_WKE = ADDR_W'(5);
  localparam logic [CNT_W-1:0]  ONE   = CNT_W'(1);
  localparam logic [CNT_W-2:0]  PAD   = '0;

  logic [CNT_W-1:0] ivl_q, cnt_q;
  logic run_q, ien_q, wke_q, pend_q;

  logic load, step, expire, clr;
  assign load   = wr_en && (wr_addr == A_IVL);
  assign step   = sec_tick && run_q && !load && (cnt_q != '0);
  assign expire = step && (cnt_q == ONE);
  assign clr    = wr_en && (wr_addr == A_STS) && wr_data[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ivl_q <= '0;
      cnt_q <= '0;
    end else if (load) begin
      ivl_q <= wr_data;
      cnt_q <= wr_data;
    end else if (step) begin
      cnt_q <= cnt_q - ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      ien_q <= 1'b0;
      wke_q <= 1'b0;
    end else if (wr_en) begin
      if (wr_addr == A_RUN) run_q <= wr_data[0];
      if (wr_addr == A_IEN) ien_q <= wr_data[0];
      if (wr_addr == A_WKE) wke_q <= wr_data[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= expire | (pend_q & ~clr);
  end

  assign irq  = pend_q & ien_q;
  assign wake = pend_q & wke_q;

  always_comb begin
    case (rd_addr)
      A_IVL:   rd_data = ivl_q;
      A_REM:   rd_data = cnt_q;
      A_RUN:   rd_data = {PAD, run_q};
      A_IEN:   rd_data = {PAD, ien_q};
      A_STS:   rd_data = {PAD, pend_q};
      A_WKE:   rd_data = {PAD, wke_q};
      default: rd_data = '0;
    endcase
  end

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && run_q && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - ONE)); // R3
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_tick && !load) |=> $stable(cnt_q)); // R3
  AST_ZERO_REST: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !load) |=> (cnt_q == '0)); // R4
  AST_EXPIRY_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && run_q && !load && cnt_q == ONE) |=> pend_q); // R9
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && !(sec_tick && run_q && !load && cnt_q == ONE)) |=> !pend_q); // R5
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_STS && wr_data[0] && !(sec_tick && run_q && cnt_q == ONE)) |=> !pend_q); // R6
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_IVL) |=> (cnt_q == $past(wr_data))); // R10

endmodule

// File: tb/test_sec_countdown_alarm.sv
module test_sec_countdown_alarm;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0, sec_tick = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic irq, wake;

  sec_countdown_alarm i_sec_countdown_alarm (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq(irq), .wake(wake));

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  longint unsigned m_ivl, m_cnt;
  bit m_run, m_ien, m_wke, m_pend;

  always @(posedge clk) begin : model
    bit ld, stp, ex, cl;
    if (!rst_n) begin
      m_ivl = 0; m_cnt = 0; m_run = 0; m_ien = 0; m_wke = 0; m_pend = 0;
    end else begin
      ld  = wr_en && wr_addr == 0;
      stp = sec_tick && m_run && !ld && m_cnt != 0;
      ex  = stp && m_cnt == 1;
      cl  = wr_en && wr_addr == 4 && wr_data[0];
      if (ld) begin m_ivl = wr_data; m_cnt = wr_data; end
      else if (stp) m_cnt = m_cnt - 1;
      if (wr_en && wr_addr == 2) m_run = wr_data[0];
      if (wr_en && wr_addr == 3) m_ien = wr_data[0];
      if (wr_en && wr_addr == 5) m_wke = wr_data[0];
      m_pend = ex || (m_pend && !cl);
    end
  end

  function automatic longint unsigned model_rd(input int a);
    case (a)
      0: return m_ivl;
      1: return m_cnt;
      2: return m_run;
      3: return m_ien;
      4: return m_pend;
      5: return m_wke;
      default: return 0;
    endcase
  endfunction

  function automatic string req_of(input int a);
    case (a)
      0: return "R2";
      1: return "R3";
      4: return "R6";
      default: return "R1";
    endcase
  endfunction

  task automatic chk(input string req, input longint unsigned act, input longint unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_model();
    chk("R7", irq, m_pend & m_ien);
    chk("R8", wake, m_pend & m_wke);
    chk(req_of(int'(rd_addr)), rd_data, model_rd(int'(rd_addr)));
  endtask

  task automatic drive(input bit t, input bit we, input int a, input int unsigned d, input int ra);
    @(negedge clk);
    compare_model();
    sec_tick = t; wr_en = we; wr_addr = 3'(a); wr_data = d; rd_addr = 3'(ra);
  endtask

  task automatic idle(); drive(0, 0, 0, 0, int'(rd_addr)); endtask
  task automatic wr(input int a, input int unsigned d); drive(0, 1, a, d, int'(rd_addr)); endtask
  task automatic tk(); drive(1, 0, 0, 0, int'(rd_addr)); endtask

  task automatic expect_rd(input int a, input longint unsigned exp, input string req);
    idle();
    rd_addr = 3'(a);
    #1;
    chk(req, rd_data, exp);
  endtask

  task automatic expect_out(input bit ei, input bit ew, input string req);
    idle();
    #1;
    chk({req, " irq"}, irq, ei);
    chk({req, " wake"}, wake, ew);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 8; a++) expect_rd(a, 0, "R1");
    expect_out(0, 0, "R1");
    // R2 load
    wr(0, 3);
    expect_rd(0, 3, "R2");
    expect_rd(1, 3, "R2");
    // R11 remaining is read only
    wr(1, 99);
    expect_rd(1, 3, "R11");
    // R3 no decrement without run
    tk(); tk();
    expect_rd(1, 3, "R3");
    wr(2, 1); wr(3, 1); wr(5, 1);
    tk();
    expect_rd(1, 2, "R3");
    idle(); idle();
    expect_rd(1, 2, "R3");
    tk();
    expect_rd(1, 1, "R3");
    expect_rd(4, 0, "R4");
    tk();
    expect_rd(4, 1, "R4");
    expect_out(1, 1, "R7");
    tk(); tk();
    expect_rd(1, 0, "R4");
    // R6 clear semantics
    wr(4, 32'hFFFF_FFFE);
    expect_rd(4, 1, "R6");
    wr(4, 1);
    expect_rd(4, 0, "R6");
    expect_out(0, 0, "R6");
    // R7 and R8 gating
    wr(0, 2); tk(); tk();
    wr(3, 0);
    expect_out(0, 1, "R7");
    wr(5, 0); wr(3, 1);
    expect_out(1, 0, "R8");
    wr(4, 1);
    // R5 zero interval while running
    wr(0, 0);
    repeat (4) tk();
    expect_rd(4, 0, "R5");
    expect_rd(1, 0, "R5");
    // R9 clear and expiry collide
    wr(0, 1); tk();
    expect_rd(4, 1, "R9");
    wr(0, 1);
    drive(1, 1, 4, 1, 4);
    expect_rd(4, 1, "R9");
    wr(4, 1);
    expect_rd(4, 0, "R9");
    // R10 load and tick collide
    wr(0, 5);
    drive(1, 1, 0, 7, 1);
    expect_rd(1, 7, "R10");
    tk();
    expect_rd(1, 6, "R10");
    // random mixed traffic against the model
    for (int i = 0; i < 2000; i++) begin
      int a;
      int unsigned d;
      a = $urandom_range(0, 7);
      d = (a == 0) ? $urandom_range(0, 4) : $urandom;
      drive($urandom_range(0, 1) == 1, $urandom_range(0, 3) == 0, a, d, $urandom_range(0, 7));
    end
    idle();
    finish_run();
  end
endmodule